// File: doc/BRIEF.md
# Reset and Clock-Start Sequencer

This block governs how a small system enters and leaves reset under the control of one external active-low reset pin. While the pin is low, every managed output is held in its safe state without waiting for a clock edge: the CPU and peripherals stay in reset, the clock gates stay closed, the main and ring oscillator enables are off, and the I/O pads are held in high impedance. The slow subclock oscillator is the only source that keeps running.

When the pin goes high, the release passes through a reset synchronizer into the main clock domain. The oscillators then restart and the watchdog enable turns on at once. A stabilization counter then runs for 2^STAB_BITS main-clock cycles. Only when that count is complete do the peripheral, system and CPU clock enables open and the CPU and peripheral resets lift. A status output marks that moment. The CPU clock divider select leaves reset at the divide-by-8 code. If the pin drops again at any point, the sequence returns to its reset state and a later release starts the full count again.

Top module: `rstseq_top`

## Requirements
- R1: While `rst_pin_n` is low, every enable output except `osc_sub_en` is low and both reset outputs are low, and this takes effect without a clock edge.
- R2: The release passes through a two-stage synchronizer. `osc_main_en` rises after the third rising clock edge that samples `rst_pin_n` high, counted from the edge right after the pin went high.
- R3: `cpu_rst_n` rises exactly 2^STAB_BITS clock cycles after `osc_main_en` rises. With the default STAB_BITS=16 this is 65536 cycles.
- R4: `osc_main_en` and `osc_ring_en` are low during reset and high from the release point of R2 onward.
- R5: `osc_sub_en` is high at all times, including during reset.
- R6: `periph_clk_en`, `sys_clk_en` and `cpu_clk_en` stay low until the stabilization count finishes, and they rise in the same cycle as `cpu_rst_n`. `periph_rst_n` rises in that cycle too.
- R7: `cpu_div_sel` holds the code 3 from reset onward. The code n selects division of the system clock by 2^n, so 3 means divide-by-8.
- R8: `pad_oe_allow` is low (pads in high impedance) during reset and during the stabilization count. It rises together with `cpu_rst_n`.
- R9: `wdt_en` rises in the same cycle as `osc_main_en` and does not wait for the stabilization count.
- R10: A low level on `rst_pin_n` during the stabilization count clears the count. After the next release, the full count of R2 and R3 is needed again.
- R11: `stab_done` is low until the count completes and rises in the same cycle as `cpu_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| osc_main_en | output | 1 | Main oscillator enable |
| osc_ring_en | output | 1 | Ring oscillator enable |
| osc_sub_en | output | 1 | Subclock oscillator enable, always on |
| wdt_en | output | 1 | Watchdog enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| sys_clk_en | output | 1 | Internal system clock gate enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| cpu_rst_n | output | 1 | CPU reset, active low |
| pad_oe_allow | output | 1 | Pad output enable permission; low forces high impedance |
| cpu_div_sel | output | DIV_W | CPU clock divider code, 2^code |
| stab_done | output | 1 | Stabilization complete and CPU released |

## Verification
A fall of the reset pin must show on every output in the same cycle, before the next clock edge. The bench therefore drives the pin just after a rising edge and compares all outputs at the following falling edge. After a release, the oscillator and watchdog enables are due after the third rising edge that sees the pin high. The clock enables, resets, pad permission and status are due 2^STAB_BITS edges after that. A bench counter that clears whenever the pin is low counts the edges, and every output is compared at each falling edge against the value these two thresholds give. Directed runs also measure both intervals directly, including after a restart in the middle of a count.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

   typedef enum logic [1:0] {
      SEQ_HOLD = 2'd0,
      SEQ_STAB = 2'd1,
      SEQ_RUN  = 2'd2
   } seq_state_t;

   // divider code n selects f/2^n; 3 gives divide-by-8
   localparam int unsigned DIV_CODE_BY8 = 3;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rstseq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stg;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) stg <= '0;
      else         stg <= {stg[STAGES-2:0], 1'b1};
   end

   assign q = stg[STAGES-1];

   // ones enter at the front, so the last stage cannot be set ahead of the first
   assert_sync_order_R2: assert property (@(posedge clk) disable iff (!arst_n)
      q |-> stg[0]);

endmodule

// File: rtl/rstseq_stab_cnt.sv
module rstseq_stab_cnt #(
   parameter int BITS  = 16,
   parameter bit SPLIT = 1'b1
) (
   input  logic clk,
   input  logic arst_n,
   input  logic clr,
   input  logic en,
   output logic term
);

   if (BITS < 2) begin : g_bad_bits
      $error("rstseq_stab_cnt: BITS must be at least 2");
   end

   if (SPLIT && BITS >= 4) begin : g_split
      // two halves with a registered-free carry keep the adder depth at BITS/2
      localparam int LO_W = BITS / 2;
      localparam int HI_W = BITS - LO_W;
      logic [LO_W-1:0] lo;
      logic [HI_W-1:0] hi;
      logic            lo_full;

      assign lo_full = &lo;

      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) begin
            lo <= '0;
            hi <= '0;
         end else if (clr) begin
            lo <= '0;
            hi <= '0;
         end else if (en) begin
            lo <= lo + 1'b1;
            if (lo_full) hi <= hi + 1'b1;
         end
      end

      assign term = lo_full & (&hi);

      assert_cnt_clear_R10: assert property (@(posedge clk) disable iff (!arst_n)
         clr |=> (lo == '0 && hi == '0));
   end else begin : g_flat
      logic [BITS-1:0] cnt;

      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n)  cnt <= '0;
         else if (clr) cnt <= '0;
         else if (en)  cnt <= cnt + 1'b1;
      end

      assign term = &cnt;

      assert_cnt_clear_R10: assert property (@(posedge clk) disable iff (!arst_n)
         clr |=> (cnt == '0));
   end

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
   import rstseq_pkg::*;
#(
   parameter int DIV_W     = 3,
   parameter int DIV_RESET = 3
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             rel_sync,
   input  logic             cnt_term,
   output logic             cnt_clr,
   output logic             cnt_en,
   output logic             osc_on,
   output logic             run_on,
   output logic [DIV_W-1:0] div_sel
);

   if (DIV_RESET >= (1 << DIV_W)) begin : g_bad_div
      $error("rstseq_ctrl: DIV_RESET does not fit in DIV_W bits");
   end

   seq_state_t state, nxt;
   logic       osc_q, run_q;
   logic [DIV_W-1:0] div_q;

   always_comb begin
      nxt = state;
      unique case (state)
         SEQ_HOLD: if (rel_sync) nxt = SEQ_STAB;
         SEQ_STAB: if (cnt_term) nxt = SEQ_RUN;
         SEQ_RUN:  nxt = SEQ_RUN;
         default:  nxt = SEQ_HOLD;
      endcase
      if (!rel_sync) nxt = SEQ_HOLD;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state <= SEQ_HOLD;
         osc_q <= 1'b0;
         run_q <= 1'b0;
         div_q <= DIV_W'(DIV_RESET);
      end else begin
         state <= nxt;
         osc_q <= (nxt != SEQ_HOLD);
         run_q <= (nxt == SEQ_RUN);
      end
   end

   assign cnt_clr = (state != SEQ_STAB);
   assign cnt_en  = (state == SEQ_STAB);
   assign osc_on  = osc_q;
   assign run_on  = run_q;
   assign div_sel = div_q;

   always @(negedge clk) begin
      if (!arst_n) begin
         assert_hold_outputs_R1: assert (!osc_q && !run_q && state == SEQ_HOLD)
            else $error("outputs not held during reset");
      end
   end

   assert_run_after_term_R3: assert property (@(posedge clk) disable iff (!arst_n)
      (state == SEQ_STAB && cnt_term) |=> run_q);

   assert_no_early_run_R6: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(run_q) |-> $past(cnt_term));

   assert_osc_before_run_R4: assert property (@(posedge clk) disable iff (!arst_n)
      run_q |-> osc_q);

   assert_osc_needs_sync_R2: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(osc_q) |-> $past(rel_sync));

   assert_div_hold_R7: assert property (@(posedge clk) disable iff (!arst_n)
      $stable(div_q));

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
   import rstseq_pkg::*;
#(
   parameter int STAB_BITS   = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit CNT_SPLIT   = 1'b1,
   parameter int DIV_W       = 3
) (
   input  logic             clk,
   input  logic             rst_pin_n,
   output logic             osc_main_en,
   output logic             osc_ring_en,
   output logic             osc_sub_en,
   output logic             wdt_en,
   output logic             periph_clk_en,
   output logic             sys_clk_en,
   output logic             cpu_clk_en,
   output logic             periph_rst_n,
   output logic             cpu_rst_n,
   output logic             pad_oe_allow,
   output logic [DIV_W-1:0] cpu_div_sel,
   output logic             stab_done
);

   localparam int DIV_RESET = int'(DIV_CODE_BY8);

   logic rel_sync, cnt_clr, cnt_en, cnt_term, osc_on, run_on;

   rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (rst_pin_n),
      .q      (rel_sync)
   );

   rstseq_stab_cnt #(.BITS(STAB_BITS), .SPLIT(CNT_SPLIT)) u_cnt (
      .clk    (clk),
      .arst_n (rst_pin_n),
      .clr    (cnt_clr),
      .en     (cnt_en),
      .term   (cnt_term)
   );

   rstseq_ctrl #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_ctrl (
      .clk      (clk),
      .arst_n   (rst_pin_n),
      .rel_sync (rel_sync),
      .cnt_term (cnt_term),
      .cnt_clr  (cnt_clr),
      .cnt_en   (cnt_en),
      .osc_on   (osc_on),
      .run_on   (run_on),
      .div_sel  (cpu_div_sel)
   );

   assign osc_main_en   = osc_on;
   assign osc_ring_en   = osc_on;
   assign wdt_en        = osc_on;
   assign osc_sub_en    = 1'b1;
   assign periph_clk_en = run_on;
   assign sys_clk_en    = run_on;
   assign cpu_clk_en    = run_on;
   assign periph_rst_n  = run_on;
   assign cpu_rst_n     = run_on;
   assign pad_oe_allow  = run_on;
   assign stab_done     = run_on;

   assert_wdt_with_osc_R9: assert property (@(posedge clk) disable iff (!rst_pin_n)
      $rose(osc_main_en) |-> !stab_done);

endmodule

// File: tb/sim_rstseq_top.sv
module sim_rstseq_top;

   localparam int STAB   = 10;
   localparam int FULL   = 1 << STAB;
   localparam int OSC_AT = 3;
   localparam int RUN_AT = OSC_AT + FULL;

   logic clk = 1'b0;
   logic rst_pin_n = 1'b0;
   logic osc_main_en, osc_ring_en, osc_sub_en, wdt_en;
   logic periph_clk_en, sys_clk_en, cpu_clk_en, periph_rst_n, cpu_rst_n;
   logic pad_oe_allow, stab_done;
   logic [2:0] cpu_div_sel;

   int vectors = 0;
   int miscompares = 0;
   int rel_cnt = 0;
   bit chk_on = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rstseq_top #(.STAB_BITS(STAB)) u0 (
      .clk(clk), .rst_pin_n(rst_pin_n),
      .osc_main_en(osc_main_en), .osc_ring_en(osc_ring_en), .osc_sub_en(osc_sub_en),
      .wdt_en(wdt_en), .periph_clk_en(periph_clk_en), .sys_clk_en(sys_clk_en),
      .cpu_clk_en(cpu_clk_en), .periph_rst_n(periph_rst_n), .cpu_rst_n(cpu_rst_n),
      .pad_oe_allow(pad_oe_allow), .cpu_div_sel(cpu_div_sel), .stab_done(stab_done)
   );

   // edges seen with the pin high since the last release
   always @(posedge clk or negedge rst_pin_n) begin
      if (!rst_pin_n) rel_cnt <= 0;
      else if (rel_cnt < RUN_AT + 10) rel_cnt <= rel_cnt + 1;
   end

   function automatic bit exp_osc(input bit pin, input int n);
      return pin && (n >= OSC_AT);
   endfunction

   function automatic bit exp_run(input bit pin, input int n);
      return pin && (n >= RUN_AT);
   endfunction

   task automatic cmp(input int act, input int exp, input string tag, input string what);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: got %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (chk_on) begin
         bit eo, er;
         string to, tr;
         eo = exp_osc(rst_pin_n, rel_cnt);
         er = exp_run(rst_pin_n, rel_cnt);
         to = rst_pin_n ? "R4" : "R1";
         tr = rst_pin_n ? "R6" : "R1";
         cmp(osc_main_en, eo, to, "osc_main_en");
         cmp(osc_ring_en, eo, to, "osc_ring_en");
         cmp(wdt_en, eo, "R9", "wdt_en");
         cmp(osc_sub_en, 1, "R5", "osc_sub_en");
         cmp(periph_clk_en, er, tr, "periph_clk_en");
         cmp(sys_clk_en, er, tr, "sys_clk_en");
         cmp(cpu_clk_en, er, tr, "cpu_clk_en");
         cmp(periph_rst_n, er, tr, "periph_rst_n");
         cmp(cpu_rst_n, er, "R3", "cpu_rst_n");
         cmp(pad_oe_allow, er, "R8", "pad_oe_allow");
         cmp(stab_done, er, "R11", "stab_done");
         cmp(cpu_div_sel, 3, "R7", "cpu_div_sel");
      end
   end

   task automatic hold_low(input int cyc);
      @(posedge clk); #1 rst_pin_n = 1'b0;
      repeat (cyc) @(posedge clk);
   endtask

   // release and measure edges to the oscillator enable and to the CPU release
   task automatic release_measure(output int t_osc, output int t_run);
      int n;
      t_osc = -1;
      t_run = -1;
      n = 0;
      @(posedge clk); #1 rst_pin_n = 1'b1;
      while (t_run < 0 && n < RUN_AT + 20) begin
         @(posedge clk); n++;
         @(negedge clk);
         if (osc_main_en && t_osc < 0) t_osc = n;
         if (cpu_rst_n && t_run < 0) t_run = n;
      end
   endtask

   initial begin
      int t_osc, t_run, dummy;
      dummy = $urandom(32'h2F1C_0A57);
      chk_on = 1'b1;
      repeat (4) @(posedge clk);

      // R1 reset state, directed
      @(negedge clk);
      cmp(osc_main_en, 0, "R1", "reset osc_main_en");
      cmp(cpu_rst_n, 0, "R1", "reset cpu_rst_n");
      cmp(osc_sub_en, 1, "R5", "reset osc_sub_en");
      cmp(cpu_div_sel, 3, "R7", "reset cpu_div_sel");

      // R2 / R3 full release from reset
      release_measure(t_osc, t_run);
      cmp(t_osc, OSC_AT, "R2", "edges to osc enable");
      cmp(t_run - t_osc, FULL, "R3", "stabilization length");

      // R1 asynchronous assertion, short low pulse inside one cycle
      @(posedge clk); #1 rst_pin_n = 1'b0;
      #1;
      cmp(cpu_rst_n, 0, "R1", "async cpu_rst_n");
      cmp(pad_oe_allow, 0, "R8", "async pad_oe_allow");
      cmp(osc_main_en, 0, "R1", "async osc_main_en");
      #1 rst_pin_n = 1'b1;
      repeat (RUN_AT + 4) @(posedge clk);

      // R10 reassert in mid-count, then full count again
      hold_low(3);
      @(posedge clk); #1 rst_pin_n = 1'b1;
      repeat (OSC_AT + FULL / 2) @(posedge clk);
      hold_low(2);
      release_measure(t_osc, t_run);
      cmp(t_osc, OSC_AT, "R10", "restart edges to osc enable");
      cmp(t_run - t_osc, FULL, "R10", "restart full stabilization");

      // R10 reassert one cycle before completion
      hold_low(1);
      @(posedge clk); #1 rst_pin_n = 1'b1;
      repeat (RUN_AT - 1) @(posedge clk);
      #1 rst_pin_n = 1'b0;
      #1;
      cmp(stab_done, 0, "R10", "late reassert stab_done");
      #1 rst_pin_n = 1'b1;
      repeat (RUN_AT + 3) @(posedge clk);

      // constrained random pin activity
      for (int i = 0; i < 12; i++) begin
         int lo_c, hi_c;
         lo_c = $urandom_range(1, 20);
         hi_c = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 8)
                                            : $urandom_range(FULL - 8, RUN_AT + 30);
         hold_low(lo_c);
         @(posedge clk); #1 rst_pin_n = 1'b1;
         repeat (hi_c) @(posedge clk);
      end

      repeat (4) @(posedge clk);
      chk_on = 1'b0;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(5ns * 150000);
      if (!done) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule